// File: doc/BRIEF.md
# Serial Delay-Setting Programming Port

This block is the control side of a two-channel programmable delay unit. A host
shifts 11-bit frames into it over three slow wires: a serial clock, a serial
data line and a load strobe. Each frame carries three fields. The first is a
channel selector. The second is a routing mode bit. The third is a 9-bit delay
code, which picks one of 512 delay settings. When the strobe rises, the code
goes into the selected channel's register and the mode register is updated.

The outputs control the delay cells and the output stage. There are two delay
codes and a mode flag. There is also a chain flag, which sends channel 0's input
through both delay stages so it leaves on channel 1's output. Finally there is
an enable for channel 0's output pair. When that enable is low, the output pair
parks with its true leg low and its complement leg high.

All three serial inputs are asynchronous to the system clock. The block
oversamples them through a synchronizer, so all of its state lives in the
system clock domain. After power-up, the host sends one frame per channel.

Top module: `dly_serial_prog`

## Requirements
- R1: While reset is active, and until the first load after it, both delay codes read 0, `ext_mode` and `chain_en` are 0, `q0_en` is 1 and `wr_vld` is 0.
- R2: A frame is the last 11 bits sampled, the first one sent landing in bit 0. Bit 0 is the channel selector, bit 1 the mode bit, and bits 2 to 10 the delay code, sent least significant bit first (code bit 0 is the third bit sent and code bit 8 the last).
- R3: A load with channel selector 0 writes the code into `dly0` and leaves `dly1` unchanged.
- R4: A load with channel selector 1 writes the code into `dly1` and leaves `dly0` unchanged.
- R5: A load with mode bit 0 selects dual mode: `ext_mode`=0, `chain_en`=0, `q0_en`=1, and each channel uses its own code.
- R6: A load with mode bit 1 selects extended mode: `ext_mode`=1, `chain_en`=1 and `q0_en`=0. The channel-0 pair is then parked with its true leg low and its complement leg high. The mode bit takes effect whichever channel the frame addresses.
- R7: Only a rising edge of `ser_ld` loads. The outputs take the new values on the third rising system clock edge after the strobe rises. Holding the strobe high loads nothing more.
- R8: Serial clock rising edges seen while `ser_ld` is high do not shift. The frame held in the shift register stays as it was.
- R9: Each load raises `wr_vld` for exactly one cycle, together with the new outputs. `wr_ch` then shows the channel selector that was used.
- R10: Every code 0 to 511 is stored exactly in either channel.
- R11: If more than 11 bits are shifted before a load, the earlier bits are discarded and only the last 11 make up the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data bit (asynchronous) |
| ser_ld | input | 1 | Load strobe; rising edge commits the frame (asynchronous) |
| dly0 | output | 9 | Channel-0 delay code |
| dly1 | output | 9 | Channel-1 delay code |
| ext_mode | output | 1 | 1 = extended mode, 0 = dual mode |
| chain_en | output | 1 | Route channel-0 input through both delay stages to channel-1 output |
| q0_en | output | 1 | Channel-0 output pair enable; 0 parks true low / complement high |
| wr_vld | output | 1 | One-cycle pulse after each load |
| wr_ch | output | 1 | Channel written by the latest load |

## Verification
Each serial input passes through two synchronizer flops and one edge-detect flop. A load therefore shows up on the outputs and on `wr_vld` at the third system clock rising edge after `ser_ld` rises. The bench drives all inputs at falling edges and reads the codes three falling edges after raising the strobe. In one directed case it also confirms that the old values are still present one edge earlier. Serial bits are held for four system cycles on each side of every serial clock edge, so each bit is shifted exactly once. The load pulses are counted by a monitor that samples 1 ns after each rising edge, which catches a missing or doubled pulse.

// File: rtl/dly_serial_prog.sv
module dly_serial_prog #(
  parameter int DW   = 9,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_ld,
  output logic [DW-1:0] dly0,
  output logic [DW-1:0] dly1,
  output logic          ext_mode,
  output logic          chain_en,
  output logic          q0_en,
  output logic          wr_vld,
  output logic          wr_ch
);
  localparam int FW = DW + 2;

  logic [SYNC:0] sck_p, dat_p, ld_p;
  logic [FW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      dat_p <= '0;
      ld_p  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], ser_clk};
      dat_p <= {dat_p[SYNC-1:0], ser_dat};
      ld_p  <= {ld_p[SYNC-1:0], ser_ld};
    end

  wire ld_s     = ld_p[SYNC-1];
  wire ld_rise  = ld_s & ~ld_p[SYNC];
  wire sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  wire shift_en = sck_rise & ~ld_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (shift_en) sr <= {dat_p[SYNC-1], sr[FW-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly0     <= '0;
      dly1     <= '0;
      ext_mode <= 1'b0;
      wr_vld   <= 1'b0;
      wr_ch    <= 1'b0;
    end else begin
      wr_vld <= ld_rise;
      if (ld_rise) begin
        if (sr[0]) dly1 <= sr[FW-1:2];
        else       dly0 <= sr[FW-1:2];
        ext_mode <= sr[1];
        wr_ch    <= sr[0];
      end
    end

  assign chain_en = ext_mode;
  assign q0_en    = ~ext_mode;

  p_ch1_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !wr_ch) |-> $stable(dly1));
  p_ch0_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_ch) |-> $stable(dly0));
  p_only_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |-> ($stable(dly0) && $stable(dly1) && $stable(ext_mode)));
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !wr_vld);
  p_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(sr));
  p_q0_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && $past(sr[1])) |-> (!q0_en && chain_en));
endmodule

// File: tb/tb_dly_serial_prog.sv
`timescale 1ns/1ps
module tb_dly_serial_prog;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_ld = 0;
  logic [8:0] dly0, dly1;
  logic ext_mode, chain_en, q0_en, wr_vld, wr_ch;
  int n_chk = 0, n_bad = 0, vld_cnt = 0;
  logic vld_ch = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dly_serial_prog dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .dly0(dly0), .dly1(dly1), .ext_mode(ext_mode), .chain_en(chain_en),
    .q0_en(q0_en), .wr_vld(wr_vld), .wr_ch(wr_ch));

  always @(posedge clk) begin
    #1;
    if (wr_vld) begin vld_cnt++; vld_ch = wr_ch; end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk) ser_dat = b;
    repeat (4) @(negedge clk);
    ser_clk = 1;
    repeat (4) @(negedge clk);
    ser_clk = 0;
  endtask

  task automatic send_frame(logic ch, logic m, logic [8:0] d);
    logic [10:0] f;
    f = {d, m, ch};
    for (int i = 0; i < 11; i++) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    vld_cnt = 0;
    ser_ld = 1;
    repeat (3) @(negedge clk);
    repeat (4) @(negedge clk);
    ser_ld = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_state(string tag, int e0, int e1, logic m, logic ch);
    chk({tag, " R3 dly0"}, dly0, e0);
    chk({tag, " R4 dly1"}, dly1, e1);
    chk({tag, " R5/R6 ext_mode"}, ext_mode, m);
    chk({tag, " R6 chain_en"}, chain_en, m);
    chk({tag, " R5/R6 q0_en"}, q0_en, !m);
    chk({tag, " R9 pulse count"}, vld_cnt, 1);
    chk({tag, " R9 wr_ch"}, vld_ch, ch);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e0, e1;
    repeat (3) @(negedge clk);
    chk("R1 reset dly0", dly0, 0);
    chk("R1 reset dly1", dly1, 0);
    chk("R1 reset ext", ext_mode, 0);
    chk("R1 reset q0_en", q0_en, 1);
    chk("R1 reset vld", wr_vld, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 post-reset dly0", dly0, 0);
    chk("R1 post-reset q0_en", q0_en, 1);

    // R2/R7 exact timing: frame for ch1 with extended mode, code 0x12D
    send_frame(1, 1, 9'h12D);
    @(negedge clk);
    vld_cnt = 0;
    ser_ld = 1;
    repeat (2) @(negedge clk);
    chk("R7 not yet at edge 2 dly1", dly1, 0);
    @(negedge clk);
    chk("R2/R7 at edge 3 dly1", dly1, 'h12D);
    chk("R6 ext at edge 3", ext_mode, 1);
    chk("R6 q0 parked", q0_en, 0);
    repeat (20) @(negedge clk);
    chk("R7 held strobe single load", vld_cnt, 1);
    chk("R9 wr_ch", vld_ch, 1);
    ser_ld = 0;
    repeat (4) @(negedge clk);

    // R8: shifting while strobe high is ignored; reload gives previous frame
    send_frame(0, 0, 9'h055);
    pulse_load();
    check_state("R8 setup", 'h055, 'h12D, 0, 0);
    @(negedge clk) ser_ld = 1;
    send_frame(1, 1, 9'h1AA);
    ser_ld = 0;
    repeat (4) @(negedge clk);
    pulse_load();
    check_state("R8 ignored bits", 'h055, 'h12D, 0, 0);

    // R11: extra leading bits are discarded
    send_bit(1); send_bit(1); send_bit(0);
    send_frame(0, 1, 9'h0F3);
    pulse_load();
    check_state("R11 overlong", 'h0F3, 'h12D, 1, 0);

    // R10 sweeps with R3/R4 isolation and R5/R6 mode changes
    e0 = 'h0F3; e1 = 'h12D;
    for (int k = 0; k < 512; k++) begin
      send_frame(0, k[0], k[8:0]);
      pulse_load();
      e0 = k;
      check_state("R10 ch0 sweep", e0, e1, k[0], 0);
    end
    for (int k = 0; k < 512; k++) begin
      send_frame(1, k[1], 9'(511 - k));
      pulse_load();
      e1 = 511 - k;
      check_state("R10 ch1 sweep", e0, e1, k[1], 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule